// File: doc/BRIEF.md
# Pixel Formatter with Palette

This block turns display-memory words into a stream of panel colour levels. Each accepted word is split into pixels of 1, 2, 4 or 8 bits. The byte on the low data lines comes out first, and each byte is read from its most significant bit down. Every pixel is then mapped to a 4-bit red, green and blue level. The mapping uses three independent 16-entry lookup tables that the host can rewrite at any time through a small write port.

In binary mode the pixel bit drives the levels directly. In gray modes only the green table is used, and all three outputs carry the same shade. In colour modes each channel reads its own table, so any entry is one of 4096 colours. Each channel has a 2-bit bank value. At 2 bits per pixel the bank fills the upper index bits. At 8 bits per pixel it fills the bits left over after the pixel has been split 3-3-2 across red, green and blue.

A small controller with two states sequences the work. In IDLE the block is ready. IDLE goes to EMIT when a word is offered. EMIT stays in EMIT while pixels of that word remain, and EMIT returns to IDLE in the cycle that emits the last pixel. The mode and the bank values are captured together with the word.

Top module: `pixel_formatter`

## Requirements
- R1: After reset, word_rdy is 1 and pix_vld is 0, and every lookup entry of all three tables reads as 0 until written.
- R2: A word is accepted on a rising edge where word_vld and word_rdy are both 1, and word_rdy is 0 in the following cycle. The word yields exactly (bus bits / bpp) pixels, where bus bits is 16 when cfg_wide=1 and 8 otherwise. Each pixel is presented on one cycle with pix_vld=1, and word_vld is ignored while word_rdy is 0.
- R3: Pixel order is: word_data[7:0] first, then word_data[15:8]; inside a byte, pixels are taken starting at bit 7.
- R4: cfg_depth=0 is 1 bpp binary: pixel 1 gives 4'hF on all three outputs and pixel 0 gives 4'h0, whatever the tables hold.
- R5: With cfg_color=0 at 2 or 4 bpp, all three outputs equal the green table entry at the index formed for green.
- R6: cfg_depth=1 is 2 bpp: each channel's table index is {bank, pixel[1:0]} using that channel's own bank.
- R7: cfg_depth=2 is 4 bpp: the table index is the pixel value for every channel.
- R8: cfg_depth=3 with cfg_color=1 and cfg_wide=1 is 8 bpp, and the indices are: red {p[7:5], bank_red[1]}, green {p[4:2], bank_grn[1]}, blue {p[1:0], bank_blu[1:0]}.
- R9: A request for cfg_depth=3 with cfg_color=0 or cfg_wide=0 is handled exactly as cfg_depth=2.
- R10: pal_we=1 writes pal_wdata into entry pal_addr of the table selected by pal_chan (0 red, 1 green, 2 blue). pal_chan=3 changes no entry.
- R11: With cfg_wide=0 only word_data[7:0] is used, and the word yields half the pixels of the wide case.
- R12: Mode, width and bank inputs are sampled only when a word is accepted; changing them while pixels of that word are being emitted has no effect on those pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_depth | input | 2 | Bits per pixel: 0=1, 1=2, 2=4, 3=8 |
| cfg_color | input | 1 | 1 colour, 0 gray |
| cfg_wide | input | 1 | 1 for a 16-bit memory word, 0 for 8-bit |
| bank_red | input | 2 | Red bank value |
| bank_grn | input | 2 | Green bank value |
| bank_blu | input | 2 | Blue bank value |
| word_vld | input | 1 | Memory word offered |
| word_data | input | 16 | Memory word |
| word_rdy | output | 1 | Block can take a word |
| pal_we | input | 1 | Table write strobe |
| pal_chan | input | 2 | Table select, 3 = none |
| pal_addr | input | 4 | Table entry |
| pal_wdata | input | 4 | Level to store |
| pix_vld | output | 1 | Pixel levels valid |
| pix_red | output | 4 | Red level |
| pix_grn | output | 4 | Green level |
| pix_blu | output | 4 | Blue level |

## Verification
Fixed patterns come first. Alternating and mixed bits at 1 bpp separate byte order from bit order. Ascending nibble words at 4 bpp read back every table entry, which tells an ignored spare-channel write apart from a real one. Narrow-bus and gray requests at 8 bpp show whether the fallback to 4 bpp and the halved pixel count are applied. After that, random words with random depth, colour, width and banks are mixed with random table rewrites. The mode inputs are scrambled after every acceptance, so a design that samples the configuration late shows up as wrong levels.

// File: rtl/pxfmt_pkg.sv
package pxfmt_pkg;

    typedef enum logic [1:0] {
        DEP_1 = 2'd0,
        DEP_2 = 2'd1,
        DEP_4 = 2'd2,
        DEP_8 = 2'd3
    } depth_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } unpk_state_e;

    localparam int BANK_W = 2;

    typedef struct packed {
        depth_e            depth;
        logic              color;
        logic              wide;
        logic [BANK_W-1:0] bank_r;
        logic [BANK_W-1:0] bank_g;
        logic [BANK_W-1:0] bank_b;
    } fmt_cfg_t;

endpackage

// File: rtl/pxfmt_unpacker.sv
module pxfmt_unpacker
    import pxfmt_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int BYTE_W = 8,
    localparam int NBYTES = WORD_W / BYTE_W,
    localparam int CNT_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fmt_cfg_t          cfg_in,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_rdy,
    output logic              px_stb,
    output logic [BYTE_W-1:0] px_val,
    output fmt_cfg_t          cfg_q
);

    unpk_state_e       state_q, state_d;
    logic [WORD_W-1:0] sh_q;
    logic [WORD_W-1:0] stream_w;
    logic [CNT_W-1:0]  cnt_q, npix_q, npix_d, tot_bits;
    logic [3:0]        bpp_q;
    logic              load, advance;
    fmt_cfg_t          cfg_eff;

    // byte 0 goes to the top of the stream, later bytes follow below it
    for (genvar i = 0; i < NBYTES; i++) begin : g_swz
        if (i == 0) begin : g_first
            assign stream_w[WORD_W-1-BYTE_W*i -: BYTE_W] = word_data[BYTE_W*i +: BYTE_W];
        end else begin : g_rest
            assign stream_w[WORD_W-1-BYTE_W*i -: BYTE_W] =
                cfg_in.wide ? word_data[BYTE_W*i +: BYTE_W] : '0;
        end
    end

    always_comb begin
        cfg_eff = cfg_in;
        if (cfg_in.depth == DEP_8 && (!cfg_in.color || !cfg_in.wide))
            cfg_eff.depth = DEP_4;
        tot_bits = cfg_eff.wide ? CNT_W'(WORD_W) : CNT_W'(BYTE_W);
        npix_d   = tot_bits >> cfg_eff.depth;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and control outputs
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        advance = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (word_vld) begin
                    load    = 1'b1;
                    state_d = ST_EMIT;
                end
            end
            ST_EMIT: begin
                advance = 1'b1;
                if (cnt_q == npix_q - CNT_W'(1)) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign word_rdy = (state_q == ST_IDLE);
    assign px_stb   = (state_q == ST_EMIT);
    assign bpp_q    = 4'd1 << cfg_q.depth;
    assign px_val   = sh_q[WORD_W-1 -: BYTE_W] >> (4'd8 - bpp_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            npix_q <= '0;
            cfg_q  <= '0;
        end else if (load) begin
            sh_q   <= stream_w;
            cnt_q  <= '0;
            npix_q <= npix_d;
            cfg_q  <= cfg_eff;
        end else if (advance) begin
            sh_q  <= sh_q << bpp_q;
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMIT) |-> (cnt_q < npix_q));  // R2
    AST_ACCEPT_DROPS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && word_rdy) |=> !word_rdy);  // R2
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMIT) |=> $stable(cfg_q));  // R12
    AST_NO_ILLEGAL_8BPP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMIT) |-> !(cfg_q.depth == DEP_8 && (!cfg_q.color || !cfg_q.wide)));  // R9

endmodule

// File: rtl/pxfmt_palette.sv
module pxfmt_palette #(
    parameter int ENTRIES = 16,
    parameter int LVL_W   = 4,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int NCH    = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [1:0]                 wr_chan,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [LVL_W-1:0]           wr_data,
    input  logic [NCH-1:0][IDX_W-1:0]  rd_idx,
    output logic [NCH-1:0][LVL_W-1:0]  rd_lvl
);

    logic [NCH-1:0][ENTRIES-1:0][LVL_W-1:0] mem_q;
    logic wr_hit;

    assign wr_hit = wr_en && (wr_chan < 2'(NCH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      mem_q <= '0;
        else if (wr_hit) mem_q[wr_chan][wr_idx] <= wr_data;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_rd
        assign rd_lvl[c] = mem_q[c][rd_idx[c]];
    end

    AST_SPARE_CHAN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_chan == 2'd3) |=> $stable(mem_q));  // R10
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_chan != 2'd3) |=> (mem_q[$past(wr_chan)][$past(wr_idx)] == $past(wr_data)));  // R10

endmodule

// File: rtl/pxfmt_mapper.sv
module pxfmt_mapper
    import pxfmt_pkg::*;
#(
    parameter int LVL_W = 4,
    localparam int IDX_W = 4,
    localparam int NCH   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      px_stb,
    input  logic [7:0]                px_val,
    input  fmt_cfg_t                  cfg_q,
    output logic [NCH-1:0][IDX_W-1:0] rd_idx,
    input  logic [NCH-1:0][LVL_W-1:0] rd_lvl,
    output logic                      pix_vld,
    output logic [LVL_W-1:0]          pix_red,
    output logic [LVL_W-1:0]          pix_grn,
    output logic [LVL_W-1:0]          pix_blu
);

    logic [NCH-1:0][LVL_W-1:0] lvl_d;
    depth_e                    dep_q;
    logic                      col_q;

    always_comb begin
        rd_idx = '0;
        unique case (cfg_q.depth)
            DEP_1: rd_idx = '0;
            DEP_2: begin
                rd_idx[0] = {cfg_q.bank_r, px_val[1:0]};
                rd_idx[1] = {cfg_q.bank_g, px_val[1:0]};
                rd_idx[2] = {cfg_q.bank_b, px_val[1:0]};
            end
            DEP_4: begin
                rd_idx[0] = px_val[3:0];
                rd_idx[1] = px_val[3:0];
                rd_idx[2] = px_val[3:0];
            end
            DEP_8: begin
                rd_idx[0] = {px_val[7:5], cfg_q.bank_r[1]};
                rd_idx[1] = {px_val[4:2], cfg_q.bank_g[1]};
                rd_idx[2] = {px_val[1:0], cfg_q.bank_b};
            end
            default: rd_idx = '0;
        endcase
    end

    always_comb begin
        if (cfg_q.depth == DEP_1) begin
            for (int c = 0; c < NCH; c++) lvl_d[c] = px_val[0] ? '1 : '0;
        end else if (cfg_q.color) begin
            lvl_d = rd_lvl;
        end else begin
            for (int c = 0; c < NCH; c++) lvl_d[c] = rd_lvl[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_vld <= 1'b0;
            pix_red <= '0;
            pix_grn <= '0;
            pix_blu <= '0;
            dep_q   <= DEP_1;
            col_q   <= 1'b0;
        end else begin
            pix_vld <= px_stb;
            if (px_stb) begin
                pix_red <= lvl_d[0];
                pix_grn <= lvl_d[1];
                pix_blu <= lvl_d[2];
                dep_q   <= cfg_q.depth;
                col_q   <= cfg_q.color;
            end
        end
    end

    AST_VLD_FOLLOWS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |-> $past(px_stb));  // R2
    AST_BINARY_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_vld && dep_q == DEP_1) |-> (pix_red == pix_grn && pix_grn == pix_blu
                                         && (pix_grn == '0 || pix_grn == '1)));  // R4
    AST_GRAY_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_vld && !col_q) |-> (pix_red == pix_grn && pix_grn == pix_blu));  // R5

endmodule

// File: rtl/pixel_formatter.sv
module pixel_formatter
    import pxfmt_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int ENTRIES = 16,
    parameter int LVL_W   = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_depth,
    input  logic              cfg_color,
    input  logic              cfg_wide,
    input  logic [1:0]        bank_red,
    input  logic [1:0]        bank_grn,
    input  logic [1:0]        bank_blu,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_rdy,
    input  logic              pal_we,
    input  logic [1:0]        pal_chan,
    input  logic [IDX_W-1:0]  pal_addr,
    input  logic [LVL_W-1:0]  pal_wdata,
    output logic              pix_vld,
    output logic [LVL_W-1:0]  pix_red,
    output logic [LVL_W-1:0]  pix_grn,
    output logic [LVL_W-1:0]  pix_blu
);

    fmt_cfg_t                cfg_in, cfg_q;
    logic                    px_stb;
    logic [7:0]              px_val;
    logic [2:0][IDX_W-1:0]   rd_idx;
    logic [2:0][LVL_W-1:0]   rd_lvl;

    always_comb begin
        cfg_in.depth  = depth_e'(cfg_depth);
        cfg_in.color  = cfg_color;
        cfg_in.wide   = cfg_wide;
        cfg_in.bank_r = bank_red;
        cfg_in.bank_g = bank_grn;
        cfg_in.bank_b = bank_blu;
    end

    pxfmt_unpacker #(.WORD_W(WORD_W)) u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_in    (cfg_in),
        .word_vld  (word_vld),
        .word_data (word_data),
        .word_rdy  (word_rdy),
        .px_stb    (px_stb),
        .px_val    (px_val),
        .cfg_q     (cfg_q)
    );

    pxfmt_palette #(.ENTRIES(ENTRIES), .LVL_W(LVL_W)) u_pal (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pal_we),
        .wr_chan (pal_chan),
        .wr_idx  (pal_addr),
        .wr_data (pal_wdata),
        .rd_idx  (rd_idx),
        .rd_lvl  (rd_lvl)
    );

    pxfmt_mapper #(.LVL_W(LVL_W)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .px_stb  (px_stb),
        .px_val  (px_val),
        .cfg_q   (cfg_q),
        .rd_idx  (rd_idx),
        .rd_lvl  (rd_lvl),
        .pix_vld (pix_vld),
        .pix_red (pix_red),
        .pix_grn (pix_grn),
        .pix_blu (pix_blu)
    );

endmodule

// File: tb/pixel_formatter_tb_top.sv
module pixel_formatter_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_depth = '0;
    logic        cfg_color = 1'b0;
    logic        cfg_wide = 1'b1;
    logic [1:0]  bank_red = '0, bank_grn = '0, bank_blu = '0;
    logic        word_vld = 1'b0;
    logic [15:0] word_data = '0;
    logic        word_rdy;
    logic        pal_we = 1'b0;
    logic [1:0]  pal_chan = '0;
    logic [3:0]  pal_addr = '0;
    logic [3:0]  pal_wdata = '0;
    logic        pix_vld;
    logic [3:0]  pix_red, pix_grn, pix_blu;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;

    int pm [3][16];
    logic [11:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pixel_formatter dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_color(cfg_color),
        .cfg_wide(cfg_wide), .bank_red(bank_red), .bank_grn(bank_grn), .bank_blu(bank_blu),
        .word_vld(word_vld), .word_data(word_data), .word_rdy(word_rdy),
        .pal_we(pal_we), .pal_chan(pal_chan), .pal_addr(pal_addr), .pal_wdata(pal_wdata),
        .pix_vld(pix_vld), .pix_red(pix_red), .pix_grn(pix_grn), .pix_blu(pix_blu)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] ref_pix(int d, bit col, int br, int bg, int bb, int pv);
        int ir, ig, ib, r, g, b;
        if (d == 0) begin
            r = pv[0] ? 15 : 0;
            return {4'(r), 4'(r), 4'(r)};
        end
        if (d == 1) begin
            ir = (br << 2) | pv; ig = (bg << 2) | pv; ib = (bb << 2) | pv;
        end else if (d == 2) begin
            ir = pv; ig = pv; ib = pv;
        end else begin
            ir = (((pv >> 5) & 7) << 1) | (br >> 1);
            ig = (((pv >> 2) & 7) << 1) | (bg >> 1);
            ib = ((pv & 3) << 2) | bb;
        end
        g = pm[1][ig];
        if (col) begin r = pm[0][ir]; b = pm[2][ib]; end
        else     begin r = g; b = g; end
        return {4'(r), 4'(g), 4'(b)};
    endfunction

    // monitor: compare every emitted pixel with the expected queue
    always @(negedge clk) begin
        if (mon_on && pix_vld) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "extra pixel", 1, 0);
            end else begin
                logic [11:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({pix_red, pix_grn, pix_blu} == e, t, "pixel rgb",
                      {pix_red, pix_grn, pix_blu}, e);
            end
        end
    end

    task automatic pal_write(int ch, int idx, int val);
        @(negedge clk);
        pal_we = 1'b1; pal_chan = 2'(ch); pal_addr = 4'(idx); pal_wdata = 4'(val);
        if (ch != 3) pm[ch][idx] = val;
        @(negedge clk);
        pal_we = 1'b0;
    endtask

    task automatic send_word(logic [15:0] data, int dep, bit col, bit wide,
                             int br, int bg, int bb, string tag);
        int d, bpp, n, off, bv, pv;
        string t;
        @(negedge clk);
        while (!word_rdy) @(negedge clk);
        cfg_depth = 2'(dep); cfg_color = col; cfg_wide = wide;
        bank_red = 2'(br); bank_grn = 2'(bg); bank_blu = 2'(bb);
        word_data = data; word_vld = 1'b1;
        d = dep;
        if (d == 3 && (!col || !wide)) d = 2;
        bpp = 1 << d;
        n = (wide ? 16 : 8) / bpp;
        if (tag != "") t = tag;
        else if (d != dep) t = "R9";
        else if (!wide) t = "R11";
        else if (d == 0) t = "R4";
        else if (!col) t = "R5";
        else if (d == 1) t = "R6";
        else if (d == 2) t = "R7";
        else t = "R8";
        for (int k = 0; k < n; k++) begin
            off = k * bpp;
            bv = (data >> ((off / 8) * 8)) & 8'hFF;
            pv = (bv >> (8 - (off % 8) - bpp)) & ((1 << bpp) - 1);
            exp_q.push_back(ref_pix(d, col, br, bg, bb, pv));
            tag_q.push_back(t);
        end
        @(negedge clk);
        check(word_rdy == 1'b0, "R2", "rdy after accept", word_rdy, 0);
        word_vld = 1'b0;
        // R12: scramble the sampled inputs while the word is being emitted
        cfg_depth = 2'($urandom); cfg_color = 1'($urandom); cfg_wide = 1'($urandom);
        bank_red = 2'($urandom); bank_grn = 2'($urandom); bank_blu = 2'($urandom);
        word_data = 16'($urandom);
    endtask

    task automatic drain();
        int guard = 0;
        @(negedge clk);
        while ((!word_rdy || exp_q.size() != 0) && guard < 100) begin
            @(negedge clk); guard++;
        end
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R2", "missing pixels", exp_q.size(), 0);
        exp_q.delete(); tag_q.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < 3; c++) for (int i = 0; i < 16; i++) pm[c][i] = 0;
        repeat (3) @(negedge clk);
        check(word_rdy == 1'b1, "R1", "rdy in reset", word_rdy, 1);
        check(pix_vld == 1'b0, "R1", "vld in reset", pix_vld, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(word_rdy == 1'b1, "R1", "rdy after reset", word_rdy, 1);
        check(pix_vld == 1'b0, "R1", "vld after reset", pix_vld, 0);
        mon_on = 1'b1;

        // R1: unwritten tables read zero
        send_word(16'h3210, 2, 1'b1, 1'b1, 0, 0, 0, "R1");
        send_word(16'hFEDC, 2, 1'b1, 1'b1, 0, 0, 0, "R1");
        drain();

        // R10: fill all tables, then spare-channel writes must change nothing
        for (int c = 0; c < 3; c++)
            for (int i = 0; i < 16; i++) pal_write(c, i, int'($urandom % 16));
        for (int i = 0; i < 16; i++) pal_write(3, i, int'($urandom % 16));
        send_word(16'h3210, 2, 1'b1, 1'b1, 0, 0, 0, "R10");
        send_word(16'h7654, 2, 1'b1, 1'b1, 0, 0, 0, "R10");
        send_word(16'hBA98, 2, 1'b1, 1'b1, 0, 0, 0, "R10");
        send_word(16'hFEDC, 2, 1'b1, 1'b1, 0, 0, 0, "R10");
        drain();

        // R3 / R4: byte and bit order at 1 bpp
        send_word(16'h0180, 0, 1'b1, 1'b1, 1, 2, 3, "R3");
        send_word(16'hA53C, 0, 1'b0, 1'b1, 0, 0, 0, "R4");
        // R6 with each bank, colour and gray (R5)
        send_word(16'h1B1B, 1, 1'b1, 1'b1, 1, 2, 3, "R6");
        send_word(16'hE4E4, 1, 1'b1, 1'b1, 3, 0, 2, "R6");
        send_word(16'h1B1B, 1, 1'b0, 1'b1, 0, 3, 1, "R5");
        // R8 / R9 / R11
        send_word(16'h5AC3, 3, 1'b1, 1'b1, 2, 3, 1, "R8");
        send_word(16'h5AC3, 3, 1'b1, 1'b0, 2, 3, 1, "R9");
        send_word(16'h5AC3, 3, 1'b0, 1'b1, 2, 3, 1, "R9");
        send_word(16'hFF96, 2, 1'b1, 1'b0, 0, 0, 0, "R11");
        send_word(16'h00F1, 0, 1'b0, 1'b0, 0, 0, 0, "R11");
        // R12: inputs scrambled after each acceptance
        send_word(16'hC3A5, 1, 1'b1, 1'b1, 2, 1, 0, "R12");
        drain();

        // random mix
        for (int w = 0; w < 120; w++) begin
            if (w % 20 == 19) begin
                drain();
                for (int k = 0; k < 6; k++)
                    pal_write(int'($urandom % 4), int'($urandom % 16), int'($urandom % 16));
            end
            send_word(16'($urandom), int'($urandom % 4), 1'($urandom), 1'($urandom),
                      int'($urandom % 4), int'($urandom % 4), int'($urandom % 4), "");
        end
        drain();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule